// File: doc/BRIEF.md
# Chunked Image Staging Mailbox Target

This block is the device end of a small memory-mapped mailbox through which a host pushes an image in pieces. The host addresses four 32-bit registers: control, status, write data and read data. It streams one framed request per transaction into the write-data register. A request is a mailbox header, then a command header, then payload dwords. The host then sets the go bit in control. The target checks the framing, holds the payload in a small internal buffer and replays it, one dword per cycle, on a staging write port at the image dword address it had asked for. It then raises ready, or raises error if the framing was wrong.

After each transaction the target offers a four-dword response on the read-data register. The host reads one dword and writes zero to the same register to step to the next one. The response names the byte offset of the image that the target wants next. To model limited internal resources, the target throws away every Nth valid chunk and asks for the same offset again. When the whole image has been staged it answers with the all-ones offset. An abort bit in control returns the mailbox and the staging progress to their initial state at any time.

Top module: `mbx_stage_target`

## Requirements
- R1: After reset the status register reads 0 and the read-data register reads 0.
- R2: Dwords written to byte offset 0x8 are taken in order: mailbox header low, mailbox header high, command low, command high, then payload. The mailbox header low dword carries VENDOR_ID in bits 15:0 and object type 0x0B in bits 23:16. The high dword carries the total object size in dwords, which is 4 plus the payload count. The command header is low 3, high 0.
- R3: Writing bit 31 (go) to control at offset 0x0 on a valid request makes status (offset 0x4) read 0x8000_0000, with ready in bit 31 and error bit 2 clear.
- R4: A request with a wrong vendor, type or command, a size field that differs from the dwords written, no payload, more payload than BUF_DWORDS, or a payload that runs past the image end makes status read 0x0000_0004. Its response carries the unchanged offset and status dword 4, and it makes no staging writes.
- R5: Each accepted chunk is written to the staging port in order, at dword addresses starting from the requested offset, once per dword, with the data as sent.
- R6: Response dword 0 is {8'h00, 8'h0B, VENDOR_ID} and dword 1 is 4 (the response size in dwords).
- R7: Response dword 2 is the next wanted byte offset and dword 3 is the outcome. Outcome 2 means more is needed. When the image is complete the offset is 0xFFFF_FFFF and the outcome is 1. Valid requests after completion get the same reply and cause no writes.
- R8: Counting valid requests since the last abort, while the image is not complete, every RETRY_EVERY-th one is discarded. It makes no writes and its response repeats the same offset with outcome 2.
- R9: Writing 0 to offset 0xC advances the response to its next dword. A nonzero write there changes nothing. After the fourth dword the register reads 0.
- R10: Writing bit 0 of control clears status, any partly written request, the staging progress (offset back to 0) and the discard count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr, combinational |
| stg_we | output | 1 | Staging write strobe |
| stg_addr | output | $clog2(IMAGE_DWORDS+1) | Image dword address of the staged word |
| stg_data | output | 32 | Staged image dword |

## Verification
The main function is driven as a host would drive it, by following the offsets the target asks for. Every chunk size from one dword to the full buffer is swept over a 40-dword image. Sizes that divide the image and sizes that leave a short final chunk tell the exact-end case from the partial-end case. The discard cadence falls on a different chunk index for each size, which separates a correct repeat of the offset from a skipped or repeated commit. Each kind of malformed header is then sent on its own to show that only that fault raises error, and so are an oversized payload and a chunk that overruns the image end. Abort is tried mid-request and mid-image.

// File: rtl/mbx_stage_pkg.sv
// Package: register offsets, bit positions, codes and FSM type shared by
// the staging mailbox target. Assumes a 32-bit register interface.
package mbx_stage_pkg;
    localparam logic [3:0]  REG_CTRL  = 4'h0;
    localparam logic [3:0]  REG_STAT  = 4'h4;
    localparam logic [3:0]  REG_WDATA = 4'h8;
    localparam logic [3:0]  REG_RDATA = 4'hC;

    localparam int          CTRL_ABORT = 0;
    localparam int          CTRL_GO    = 31;
    localparam int          STAT_ERR   = 2;
    localparam int          STAT_RDY   = 31;

    localparam logic [7:0]  OBJ_STAGE  = 8'h0B;
    localparam logic [31:0] CMD_LOAD   = 32'd3;
    localparam logic [31:0] RESP_DWORDS = 32'd4;

    localparam logic [31:0] OUT_OK   = 32'd1;
    localparam logic [31:0] OUT_MORE = 32'd2;
    localparam logic [31:0] OUT_FAIL = 32'd4;
    localparam logic [31:0] OFF_END  = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_DRAIN,
        ST_FINISH
    } stage_st_t;
endpackage

// File: rtl/mbx_req_collect.sv
// Request collector: captures the four header dwords and up to BUF_DWORDS
// payload dwords in arrival order. Counts every dword and flags overflow
// once the buffer is full. Assumes the caller gates push while busy.
module mbx_req_collect #(
    parameter int BUF_DWORDS = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                clear,
    input  logic                                push,
    input  logic [31:0]                         push_data,
    input  logic [$clog2(BUF_DWORDS)-1:0]       rd_idx,
    output logic [31:0]                         rd_data,
    output logic [31:0]                         hdr_lo,
    output logic [31:0]                         hdr_hi,
    output logic [31:0]                         cmd_lo,
    output logic [31:0]                         cmd_hi,
    output logic [$clog2(BUF_DWORDS+5)-1:0]     word_cnt,
    output logic                                overflow
);
    localparam int CW   = $clog2(BUF_DWORDS + 5);
    localparam int MAXC = BUF_DWORDS + 4;

    logic [CW-1:0] cnt_q;
    logic          ovf_q;
    logic [31:0]   head_q [4];
    logic [31:0]   slots  [BUF_DWORDS];

    // Dword counter with overflow flag; clear wins over push.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (push) begin
            if (cnt_q == CW'(MAXC)) ovf_q <= 1'b1;
            else                    cnt_q <= cnt_q + 1'b1;
        end
    end

    // Header capture for the first four dwords of a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) head_q[i] <= '0;
        end else if (push && !clear && cnt_q < CW'(4)) begin
            head_q[cnt_q[1:0]] <= push_data;
        end
    end

    // One payload register per buffer slot, written at its own count.
    for (genvar g = 0; g < BUF_DWORDS; g++) begin : g_slot
        logic [31:0] slot_q;
        always_ff @(posedge clk) begin
            if (!rst_n)                                         slot_q <= '0;
            else if (push && !clear && cnt_q == CW'(g + 4))     slot_q <= push_data;
        end
        assign slots[g] = slot_q;
    end

    assign rd_data  = slots[rd_idx];
    assign hdr_lo   = head_q[0];
    assign hdr_hi   = head_q[1];
    assign cmd_lo   = head_q[2];
    assign cmd_hi   = head_q[3];
    assign word_cnt = cnt_q;
    assign overflow = ovf_q;

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MAXC));
    p_ovf_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q |-> cnt_q == CW'(MAXC));
endmodule

// File: rtl/mbx_resp_seq.sv
// Response sequencer: latches offset and outcome of a finished transaction
// and presents the four response dwords one at a time. A zero write acks
// the current dword. Reads 0 once all four have been acked or before any load.
module mbx_resp_seq
    import mbx_stage_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'h1F2E
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        load,
    input  logic [31:0] load_off,
    input  logic [31:0] load_code,
    input  logic        ack,
    output logic [31:0] rd_word
);
    logic [2:0]  ptr_q;
    logic [31:0] off_q, code_q;

    // Pointer: restart on load, step on ack, park at 4 when exhausted.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)        ptr_q <= 3'd4;
        else if (load)              ptr_q <= 3'd0;
        else if (ack && ptr_q < 3'd4) ptr_q <= ptr_q + 3'd1;
    end

    // Latch the variable response fields.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            off_q  <= '0;
            code_q <= '0;
        end else if (load) begin
            off_q  <= load_off;
            code_q <= load_code;
        end
    end

    // Select the dword under the pointer.
    always_comb begin
        case (ptr_q)
            3'd0:    rd_word = {8'h00, OBJ_STAGE, VENDOR_ID};
            3'd1:    rd_word = RESP_DWORDS;
            3'd2:    rd_word = off_q;
            3'd3:    rd_word = code_q;
            default: rd_word = '0;
        endcase
    end

    p_ptr_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= 3'd4);
    p_ack_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !load && !clear && ptr_q < 3'd4) |=> ptr_q == $past(ptr_q) + 3'd1);
endmodule

// File: rtl/mbx_stage_ctrl.sv
// Staging controller: on go, validates the collected request, then commits
// the payload to the staging port (one dword per cycle), discards every
// RETRY_EVERY-th valid chunk, tracks the next wanted offset and completion,
// and drives status and the response. Assumes the collector is stable
// while the controller is not idle.
module mbx_stage_ctrl
    import mbx_stage_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID    = 16'h1F2E,
    parameter int          BUF_DWORDS   = 16,
    parameter int          IMAGE_DWORDS = 40,
    parameter int          RETRY_EVERY  = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                go,
    input  logic                                abort,
    input  logic [$clog2(BUF_DWORDS+5)-1:0]     word_cnt,
    input  logic                                overflow,
    input  logic [31:0]                         hdr_lo,
    input  logic [31:0]                         hdr_hi,
    input  logic [31:0]                         cmd_lo,
    input  logic [31:0]                         cmd_hi,
    input  logic [31:0]                         buf_data,
    output logic [$clog2(BUF_DWORDS)-1:0]       buf_idx,
    output logic                                busy,
    output logic                                consume,
    output logic                                stat_rdy,
    output logic                                stat_err,
    output logic                                resp_load,
    output logic [31:0]                         resp_off,
    output logic [31:0]                         resp_code,
    output logic                                stg_we,
    output logic [$clog2(IMAGE_DWORDS+1)-1:0]   stg_addr,
    output logic [31:0]                         stg_data
);
    localparam int CW = $clog2(BUF_DWORDS + 5);
    localparam int BW = $clog2(BUF_DWORDS);
    localparam int AW = $clog2(IMAGE_DWORDS + 1);
    localparam int RW = (RETRY_EVERY > 1) ? $clog2(RETRY_EVERY) : 1;

    stage_st_t   st_q;
    logic [AW-1:0] cur_q;
    logic [BW-1:0] idx_q;
    logic        done_q, rdy_q, err_q;
    logic [31:0] n32, end32, cur_bytes;
    logic        req_ok, fits, bad, take, drop_now, to_drain;

    // Request validation and chunk arithmetic.
    always_comb begin
        n32       = 32'(word_cnt) - 32'd4;
        end32     = 32'(cur_q) + n32;
        cur_bytes = 32'(cur_q) << 2;
        req_ok    = (word_cnt >= CW'(5)) && !overflow
                 && hdr_lo[15:0] == VENDOR_ID && hdr_lo[23:16] == OBJ_STAGE
                 && hdr_hi == 32'(word_cnt)
                 && cmd_lo == CMD_LOAD && cmd_hi == 32'd0;
        fits      = end32 <= 32'(IMAGE_DWORDS);
        bad       = !req_ok || (!done_q && !fits);
        take      = (st_q == ST_CHECK) && !bad && !done_q;
        to_drain  = take && !drop_now;
    end

    // Discard cadence: optional counter selected by RETRY_EVERY.
    if (RETRY_EVERY > 1) begin : g_retry
        logic [RW-1:0] rcnt_q;
        always_ff @(posedge clk) begin
            if (!rst_n || abort) rcnt_q <= '0;
            else if (take)       rcnt_q <= drop_now ? '0 : rcnt_q + 1'b1;
        end
        assign drop_now = (rcnt_q == RW'(RETRY_EVERY - 1));
    end else begin : g_noretry
        assign drop_now = 1'b0;
    end

    // Transaction sequencer and progress tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            st_q   <= ST_IDLE;
            cur_q  <= '0;
            idx_q  <= '0;
            done_q <= 1'b0;
            rdy_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: if (go) begin
                    st_q  <= ST_CHECK;
                    rdy_q <= 1'b0;
                    err_q <= 1'b0;
                end
                ST_CHECK: begin
                    idx_q <= '0;
                    if (bad) begin
                        err_q <= 1'b1;
                        st_q  <= ST_IDLE;
                    end else if (to_drain) begin
                        st_q  <= ST_DRAIN;
                    end else begin
                        rdy_q <= 1'b1;
                        st_q  <= ST_IDLE;
                    end
                end
                ST_DRAIN: begin
                    if (32'(idx_q) == n32 - 32'd1) st_q <= ST_FINISH;
                    else                           idx_q <= idx_q + 1'b1;
                end
                default: begin
                    cur_q  <= AW'(end32);
                    done_q <= (end32 == 32'(IMAGE_DWORDS));
                    rdy_q  <= 1'b1;
                    st_q   <= ST_IDLE;
                end
            endcase
        end
    end

    // Response contents for the transaction that is ending.
    always_comb begin
        resp_load = 1'b0;
        resp_off  = '0;
        resp_code = '0;
        if (st_q == ST_CHECK && !to_drain) begin
            resp_load = 1'b1;
            if (bad) begin
                resp_off  = cur_bytes;
                resp_code = OUT_FAIL;
            end else if (done_q) begin
                resp_off  = OFF_END;
                resp_code = OUT_OK;
            end else begin
                resp_off  = cur_bytes;
                resp_code = OUT_MORE;
            end
        end else if (st_q == ST_FINISH) begin
            resp_load = 1'b1;
            if (end32 == 32'(IMAGE_DWORDS)) begin
                resp_off  = OFF_END;
                resp_code = OUT_OK;
            end else begin
                resp_off  = end32 << 2;
                resp_code = OUT_MORE;
            end
        end
    end

    assign consume  = resp_load;
    assign busy     = (st_q != ST_IDLE);
    assign stat_rdy = rdy_q;
    assign stat_err = err_q;
    assign buf_idx  = idx_q;
    assign stg_we   = (st_q == ST_DRAIN);
    assign stg_addr = cur_q + AW'(idx_q);
    assign stg_data = buf_data;

    p_busy_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) |-> (!stat_rdy && !stat_err));
    p_stg_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stg_we |-> 32'(stg_addr) < 32'(IMAGE_DWORDS));
    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !abort) |=> done_q);
    p_drop_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && drop_now && !abort) |=> (!stg_we && stat_rdy));
    p_abort_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!stat_rdy && !stat_err && cur_q == '0 && !stg_we));
endmodule

// File: rtl/mbx_stage_target.sv
// Staging mailbox target top: decodes the four-register map, feeds the
// request collector, controller and response sequencer, and muxes reads.
// Assumes one-cycle write strobes and combinational register reads.
module mbx_stage_target
    import mbx_stage_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID    = 16'h1F2E,
    parameter int          BUF_DWORDS   = 16,
    parameter int          IMAGE_DWORDS = 40,
    parameter int          RETRY_EVERY  = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                bus_wr,
    input  logic [3:0]                          bus_addr,
    input  logic [31:0]                         bus_wdata,
    output logic [31:0]                         bus_rdata,
    output logic                                stg_we,
    output logic [$clog2(IMAGE_DWORDS+1)-1:0]   stg_addr,
    output logic [31:0]                         stg_data
);
    localparam int CW = $clog2(BUF_DWORDS + 5);
    localparam int BW = $clog2(BUF_DWORDS);

    logic          wr_ctrl, abort, go, push, ack, busy, consume;
    logic          stat_rdy, stat_err, resp_load;
    logic [31:0]   resp_off, resp_code, resp_word, buf_data;
    logic [31:0]   hdr_lo, hdr_hi, cmd_lo, cmd_hi;
    logic [CW-1:0] word_cnt;
    logic          overflow;
    logic [BW-1:0] buf_idx;

    // Write decode; abort has priority over go, pushes wait for idle.
    always_comb begin
        wr_ctrl = bus_wr && bus_addr == REG_CTRL;
        abort   = wr_ctrl && bus_wdata[CTRL_ABORT];
        go      = wr_ctrl && bus_wdata[CTRL_GO] && !bus_wdata[CTRL_ABORT] && !busy;
        push    = bus_wr && bus_addr == REG_WDATA && !busy;
        ack     = bus_wr && bus_addr == REG_RDATA && bus_wdata == 32'd0;
    end

    mbx_req_collect #(.BUF_DWORDS(BUF_DWORDS)) u_collect (
        .clk(clk), .rst_n(rst_n), .clear(abort || consume),
        .push(push), .push_data(bus_wdata),
        .rd_idx(buf_idx), .rd_data(buf_data),
        .hdr_lo(hdr_lo), .hdr_hi(hdr_hi), .cmd_lo(cmd_lo), .cmd_hi(cmd_hi),
        .word_cnt(word_cnt), .overflow(overflow)
    );

    mbx_stage_ctrl #(
        .VENDOR_ID(VENDOR_ID), .BUF_DWORDS(BUF_DWORDS),
        .IMAGE_DWORDS(IMAGE_DWORDS), .RETRY_EVERY(RETRY_EVERY)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .go(go), .abort(abort),
        .word_cnt(word_cnt), .overflow(overflow),
        .hdr_lo(hdr_lo), .hdr_hi(hdr_hi), .cmd_lo(cmd_lo), .cmd_hi(cmd_hi),
        .buf_data(buf_data), .buf_idx(buf_idx),
        .busy(busy), .consume(consume),
        .stat_rdy(stat_rdy), .stat_err(stat_err),
        .resp_load(resp_load), .resp_off(resp_off), .resp_code(resp_code),
        .stg_we(stg_we), .stg_addr(stg_addr), .stg_data(stg_data)
    );

    mbx_resp_seq #(.VENDOR_ID(VENDOR_ID)) u_resp (
        .clk(clk), .rst_n(rst_n), .clear(abort),
        .load(resp_load), .load_off(resp_off), .load_code(resp_code),
        .ack(ack), .rd_word(resp_word)
    );

    // Register read mux.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_STAT: begin
                bus_rdata[STAT_RDY] = stat_rdy;
                bus_rdata[STAT_ERR] = stat_err;
            end
            REG_RDATA: bus_rdata = resp_word;
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: tb/sim_mbx_stage_target.sv
`timescale 1ns/1ps
module sim_mbx_stage_target;
    localparam logic [15:0] VEN = 16'h1F2E;
    localparam int BUF = 16;
    localparam int IMG = 40;
    localparam int RET = 3;
    localparam int AW  = $clog2(IMG + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [3:0]    bus_addr = 4'h0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          stg_we;
    logic [AW-1:0] stg_addr;
    logic [31:0]   stg_data;

    int n_chk = 0, n_err = 0;
    int wr_total = 0, addr_sum = 0, mon_bad = 0;
    logic [7:0] salt = 8'h00;
    bit fin = 1'b0;
    int m_cur, m_r;
    bit m_done;

    always #10 clk = ~clk;

    mbx_stage_target #(.VENDOR_ID(VEN), .BUF_DWORDS(BUF),
                       .IMAGE_DWORDS(IMG), .RETRY_EVERY(RET)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .stg_we(stg_we), .stg_addr(stg_addr), .stg_data(stg_data));

    function automatic logic [31:0] pat(input int a);
        return {8'hC3, salt, 16'(a)};
    endfunction

    // Staging port monitor (R5): data must match the dword sent for that address.
    always @(negedge clk) begin
        if (rst_n && stg_we) begin
            wr_total++;
            addr_sum += int'(stg_addr);
            if (int'(stg_addr) >= IMG || stg_data !== pat(int'(stg_addr))) mon_bad++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic abort_all();
        wr(4'h0, 32'h0000_0001);
        m_cur = 0; m_r = 0; m_done = 1'b0;
    endtask

    // Send one request, follow the model, check status, response and writes.
    task automatic do_req(input logic [15:0] ven, input logic [7:0] typ,
                          input logic [31:0] sizef, input logic [31:0] clo,
                          input logic [31:0] chi, input int n, input int start,
                          input bit valid, input bit poke, output logic [31:0] got_off);
        logic [31:0] st, w, e_off, e_code, e_stat;
        int e_nw, w0, s0, b0, e_sum;
        w0 = wr_total; s0 = addr_sum; b0 = mon_bad;
        // expected outcome from the requirements
        if (!valid || (!m_done && m_cur + n > IMG)) begin
            e_code = 32'd4; e_off = 32'(m_cur * 4); e_stat = 32'h4; e_nw = 0;
        end else if (m_done) begin
            e_code = 32'd1; e_off = 32'hFFFF_FFFF; e_stat = 32'h8000_0000; e_nw = 0;
        end else if (m_r == RET - 1) begin
            m_r = 0;
            e_code = 32'd2; e_off = 32'(m_cur * 4); e_stat = 32'h8000_0000; e_nw = 0;
        end else begin
            m_r++;
            e_nw = n; m_cur += n; e_stat = 32'h8000_0000;
            if (m_cur == IMG) begin
                m_done = 1'b1; e_code = 32'd1; e_off = 32'hFFFF_FFFF;
            end else begin
                e_code = 32'd2; e_off = 32'(m_cur * 4);
            end
        end
        e_sum = 0;
        for (int i = 0; i < e_nw; i++) e_sum += start + i;
        wr(4'h8, {8'h00, typ, ven});
        wr(4'h8, sizef);
        wr(4'h8, clo);
        wr(4'h8, chi);
        for (int i = 0; i < n; i++) wr(4'h8, pat(start + i));
        wr(4'h0, 32'h8000_0000);
        st = '0;
        for (int k = 0; k < 200; k++) begin
            rd(4'h4, st);
            if (st[31] || st[2]) break;
        end
        chk(valid ? "R3 status" : "R4 status", st, e_stat);
        rd(4'hC, w);
        if (poke) begin
            wr(4'hC, 32'h0000_0005);
            rd(4'hC, w);
            chk("R9 nonzero ack ignored", w, {8'h00, 8'h0B, VEN});
        end
        chk("R6 resp hdr lo", w, {8'h00, 8'h0B, VEN});
        wr(4'hC, 32'd0);
        rd(4'hC, w); chk("R6 resp size", w, 32'd4);
        wr(4'hC, 32'd0);
        rd(4'hC, w); chk("R7 resp offset", w, e_off);
        got_off = w;
        wr(4'hC, 32'd0);
        rd(4'hC, w); chk("R7 resp outcome", w, e_code);
        wr(4'hC, 32'd0);
        chk("R5 write count", 32'(wr_total - w0), 32'(e_nw));
        chk("R5 address sum", 32'(addr_sum - s0), 32'(e_sum));
        chk("R5 data match", 32'(mon_bad - b0), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, off;
        int h;
        m_cur = 0; m_r = 0; m_done = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(4'h4, r); chk("R1 status after reset", r, 32'd0);
        rd(4'hC, r); chk("R1 read data after reset", r, 32'd0);

        // R4/R2: each malformed request on its own, then the good path
        abort_all();
        do_req(16'h1F2F, 8'h0B, 32'd8, 32'd3, 32'd0, 4, 0, 1'b0, 1'b0, off); // R4 vendor
        do_req(VEN, 8'h0C, 32'd8, 32'd3, 32'd0, 4, 0, 1'b0, 1'b0, off);      // R4 type
        do_req(VEN, 8'h0B, 32'd9, 32'd3, 32'd0, 4, 0, 1'b0, 1'b0, off);      // R4 size
        do_req(VEN, 8'h0B, 32'd8, 32'd2, 32'd0, 4, 0, 1'b0, 1'b0, off);      // R4 cmd
        do_req(VEN, 8'h0B, 32'd8, 32'd3, 32'd1, 4, 0, 1'b0, 1'b0, off);      // R4 cmd high
        do_req(VEN, 8'h0B, 32'd4, 32'd3, 32'd0, 0, 0, 1'b0, 1'b0, off);      // R4 empty
        do_req(VEN, 8'h0B, 32'(BUF + 5), 32'd3, 32'd0, BUF + 1, 0, 1'b0, 1'b0, off); // R4 overflow
        do_req(VEN, 8'h0B, 32'd20, 32'd3, 32'd0, 16, 0, 1'b1, 1'b1, off);    // R2 R3 R9
        do_req(VEN, 8'h0B, 32'd20, 32'd3, 32'd0, 16, 16, 1'b1, 1'b0, off);
        do_req(VEN, 8'h0B, 32'd13, 32'd3, 32'd0, 9, 32, 1'b1, 1'b0, off);    // R4 past end
        do_req(VEN, 8'h0B, 32'd12, 32'd3, 32'd0, 8, 32, 1'b1, 1'b0, off);    // R8 discard
        do_req(VEN, 8'h0B, 32'd12, 32'd3, 32'd0, 8, 32, 1'b1, 1'b0, off);    // R7 complete
        do_req(VEN, 8'h0B, 32'd12, 32'd3, 32'd0, 8, 32, 1'b1, 1'b0, off);    // R7 after end
        rd(4'hC, r); chk("R9 reads 0 after fourth dword", r, 32'd0);

        // R10: abort clears status, a partial request and progress
        abort_all();
        rd(4'h4, r); chk("R10 status after abort", r, 32'd0);
        wr(4'h8, {8'h00, 8'h0B, VEN});
        wr(4'h8, 32'd8);
        wr(4'h8, 32'd3);
        abort_all();
        do_req(VEN, 8'h0B, 32'd8, 32'd3, 32'd0, 4, 0, 1'b1, 1'b0, off);
        chk("R10 fresh request after partial abort", off, 32'd16);
        do_req(VEN, 8'h0B, 32'd8, 32'd3, 32'd0, 4, 4, 1'b1, 1'b0, off);
        abort_all();
        do_req(VEN, 8'h0B, 32'd12, 32'd3, 32'd0, 8, 0, 1'b1, 1'b0, off);
        chk("R10 progress restarts at 0", off, 32'd32);

        // R5 R7 R8: full image for every chunk size, host follows the offsets
        for (int c = 1; c <= BUF; c++) begin
            int w0, s0;
            salt = 8'(c);
            abort_all();
            w0 = wr_total; s0 = addr_sum;
            h = 0;
            for (int g = 0; g < 4 * IMG && !m_done; g++) begin
                int n;
                n = (IMG - h < c) ? IMG - h : c;
                do_req(VEN, 8'h0B, 32'(n + 4), 32'd3, 32'd0, n, h, 1'b1, 1'b0, off);
                h = (off == 32'hFFFF_FFFF) ? IMG : int'(off) / 4;
            end
            chk("R7 image complete", 32'(m_done), 32'd1);
            chk("R5 each dword once", 32'(wr_total - w0), 32'(IMG));
            chk("R5 address coverage", 32'(addr_sum - s0), 32'(IMG * (IMG - 1) / 2));
        end

        fin = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule